// File: doc/BRIEF.md
# Decoder Error Interrupt Status Register

This block collects error events reported by the units of a media decoder into one 8-bit register that a host reads over a simple synchronous strobe interface. Each error source delivers a one-cycle pulse; the matching status bit latches and holds until the host reads the register. The read returns the latched bits and clears them all in the same cycle.

The mask register sits at the same address. A host read always returns status, and a host write always loads the mask, so the two never need separate decoding. A set mask bit keeps its source from pulling the active-low interrupt line. It does not stop the status bit from latching, so a host that polls still sees masked errors. The interrupt line comes from a flop and follows a status or mask change by one clock.

Top module: `err_irq_reg`

## Requirements
- R1: After reset all status bits are 0, all mask bits are 1, `irq_n` is 1 and `rd_data` is 0.
- R2: A pulse on `evt_i` bit 0 (variable-length/run-length error), 1 (context error), 2 (audio CRC/illegal bit), 3 (audio sync), 5 (packet error) or 6 (S/PDIF channel buffer underflow) sets the same bit of the status register.
- R3: A status bit that is set stays set on every cycle without a read.
- R4: With `rd_en` high at a clock edge, `rd_data` takes the status value held before that edge and keeps it until the next read, and that edge clears every status bit.
- R5: An event that arrives at the same edge as a clearing read leaves its status bit set, so the next read returns it.
- R6: With `wr_en` high at a clock edge, mask bits 0–3, 5 and 6 take the matching bits of `wr_data`. A masked event still sets its status bit but does not drive `irq_n` low.
- R7: `irq_n` is 0 exactly when, one clock earlier, some status bit was set and its mask bit was clear. It therefore goes low one cycle after an unmasked bit sets and high one cycle after the clearing read.
- R8: Bits 4 and 7 are reserved. They always read as 0, and events or mask writes on them have no effect on `rd_data` or `irq_n`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 8 | One-cycle error event pulses, bit layout as the status register |
| rd_en | input | 1 | Host read strobe: capture status into `rd_data` and clear it |
| wr_en | input | 1 | Host write strobe: load the mask from `wr_data` |
| wr_data | input | 8 | Mask value for a write |
| rd_data | output | 8 | Status value returned by the last read |
| irq_n | output | 1 | Active-low interrupt, registered |

## Verification
A status bit that is lost or set by mistake shows up at the next read as a wrong `rd_data` value. If it is unmasked, it also shows on `irq_n` one clock after the fault. A corrupted mask bit shows only on `irq_n`, and only when its source fires, so each source is checked both masked and unmasked. A clear that fails, or a lost collision event, shows at the second of two reads done back to back.

// File: rtl/err_irq_reg.sv
module err_irq_reg #(
  parameter int W = 8,
  parameter logic [W-1:0] VALID = 8'b0110_1111
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt_i,
  input  logic         rd_en,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] rd_data,
  output logic         irq_n
);

  logic [W-1:0] status, mask;
  logic [W-1:0] hits;
  logic [W-1:0] status_nxt;

  assign hits       = evt_i & VALID;
  assign status_nxt = (rd_en ? '0 : status) | hits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status  <= '0;
      mask    <= VALID;
      rd_data <= '0;
      irq_n   <= 1'b1;
    end else begin
      status <= status_nxt;
      if (wr_en) mask <= wr_data & VALID;
      if (rd_en) rd_data <= status;
      irq_n <= ~|(status & ~mask);
    end
  end

  assert_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & $past(hits)) == $past(hits)));

  assert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> ((status & $past(status)) == $past(status)));

  assert_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> (rd_data == $past(status)));

  assert_collide_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && |hits) |=> ((status & $past(hits)) == $past(hits)));

  assert_irq_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|(status & ~mask)) |=> !irq_n);

  assert_irq_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(status & ~mask)) |=> irq_n);

  always_comb begin
    if (rst_n) assert_rsvd_R8: assert ((rd_data & ~VALID) == '0);
  end

endmodule

// File: tb/test_err_irq_reg.sv
module test_err_irq_reg;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] evt_i = '0;
  logic rd_en = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic irq_n;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  err_irq_reg i_err_irq_reg (.clk(clk), .rst_n(rst_n), .evt_i(evt_i), .rd_en(rd_en),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .irq_n(irq_n));

  always #10 clk = ~clk;

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic pulse(logic [7:0] v);
    @(negedge clk) evt_i = v;
    @(negedge clk) evt_i = '0;
  endtask

  task automatic host_read(output logic [7:0] v);
    @(negedge clk) rd_en = 1'b1;
    @(negedge clk) rd_en = 1'b0;
    v = rd_data;
  endtask

  task automatic host_write(logic [7:0] v);
    @(negedge clk) begin wr_en = 1'b1; wr_data = v; end
    @(negedge clk) wr_en = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    check("R1 irq_n", {7'd0, irq_n}, 8'h01);
    check("R1 rd_data", rd_data, 8'h00);
    host_read(v);
    check("R1 status", v, 8'h00);
  endtask

  task automatic t_masked_capture();
    logic [7:0] v;
    pulse(8'hFF);
    @(negedge clk);
    check("R6 masked irq_n", {7'd0, irq_n}, 8'h01);
    host_read(v);
    check("R2 R8 status map", v, 8'h6F);
    host_read(v);
    check("R4 cleared", v, 8'h00);
  endtask

  task automatic t_unmasked();
    logic [7:0] v;
    host_write(8'h90);
    pulse(8'h02);
    check("R7 latency", {7'd0, irq_n}, 8'h01);
    @(negedge clk);
    check("R7 asserted", {7'd0, irq_n}, 8'h00);
    repeat (5) @(negedge clk);
    check("R3 sticky irq", {7'd0, irq_n}, 8'h00);
    host_read(v);
    check("R3 R4 read", v, 8'h02);
    @(negedge clk);
    check("R7 released", {7'd0, irq_n}, 8'h01);
  endtask

  task automatic t_collision();
    logic [7:0] v;
    pulse(8'h01);
    @(negedge clk) begin rd_en = 1'b1; evt_i = 8'h20; end
    @(negedge clk) begin rd_en = 1'b0; evt_i = '0; end
    check("R4 collide read", rd_data, 8'h01);
    host_read(v);
    check("R5 kept event", v, 8'h20);
    host_read(v);
    check("R5 then clear", v, 8'h00);
  endtask

  task automatic t_per_bit_mask();
    logic [7:0] v;
    host_write(8'hBF);
    pulse(8'h01);
    @(negedge clk);
    check("R6 bit0 masked", {7'd0, irq_n}, 8'h01);
    pulse(8'h40);
    @(negedge clk);
    check("R7 bit6 unmasked", {7'd0, irq_n}, 8'h00);
    host_read(v);
    check("R6 masked still set", v, 8'h41);
  endtask

  task automatic t_reserved();
    logic [7:0] v;
    host_write(8'h00);
    pulse(8'h90);
    @(negedge clk);
    check("R8 irq_n", {7'd0, irq_n}, 8'h01);
    host_read(v);
    check("R8 read", v, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_masked_capture();
    t_unmasked();
    t_collision();
    t_per_bit_mask();
    t_reserved();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule